// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block services a circular list of transmit descriptors held in a descriptor memory next to it. Each descriptor is one 64-bit word with a 16-bit control/status half-word, a 16-bit byte count and a 32-bit buffer pointer. Software fills descriptors, sets their ready bit and pulses a poll strobe. The engine then walks the ring. For each ready descriptor it reads the buffer one byte per cycle through a byte read port. It emits those bytes on a stream with start-of-frame and end-of-frame markers and a request to append a CRC. It then writes the descriptor back with ownership returned to software.

A frame may span several descriptors, and the final one is marked as such. Frames shorter than the minimum length are padded with zero bytes. The ring wraps to a programmable base index when a descriptor carries the wrap flag. When the engine meets a descriptor that software has not handed over, it goes idle until the next poll.

Descriptor word layout: bits 15:0 control, bits 31:16 byte count, bits 63:32 buffer pointer. Control bits: 15 ready (owned by the engine), 13 wrap, 12 event request, 11 final buffer of frame, 10 append CRC, 9:0 status.

Top module: `txr_engine`

## Requirements
- R1: While reset is held, and after it until the first poll, desc_rd, desc_wr, buf_rd, tx_valid, evt_frame and evt_buf are all low.
- R2: A poll in idle makes desc_rd rise in the next cycle, at the current ring index (ring_base before the first writeback). A poll that arrives while the engine is busy is remembered and causes one more fetch at the current index once the engine has gone idle.
- R3: A fetched descriptor with control bit 15 clear produces no byte reads, no stream bytes and no writeback, and no further fetch until the next poll.
- R4: A ready descriptor with count N and pointer P issues byte reads at P, P+1, ... P+N-1 on consecutive cycles, the first one two cycles after its fetch. Each byte appears on tx_data one cycle after its read, and tx_sof marks the first byte of every frame.
- R5: A frame spans consecutive ready descriptors up to and including one with control bit 11 set. tx_eof is high on exactly one byte, the last byte of the frame.
- R6: When a frame holds fewer than 60 bytes at the end of its final buffer, zero bytes follow until it holds 60, and tx_eof marks the 60th.
- R7: tx_crc is high only together with tx_eof, and then equals control bit 10 of the frame's final descriptor.
- R8: Writeback clears bit 15 and keeps bits 14:10, the count and the pointer. Bits 9:0 become zero for a non-final descriptor. For a final descriptor they become the 7-bit mac_status zero-extended: bit 0 carrier lost, bit 1 underrun, bits 5:2 retry count, bit 6 retry limit.
- R9: After a descriptor with control bit 13 set, the next fetch is at ring_base. Otherwise it is at the index plus one, modulo the ring size.
- R10: With control bit 12 set, writeback of a final descriptor pulses evt_frame for one cycle, and writeback of a non-final one pulses evt_buf. Both pulses fall in the writeback cycle, and the two are never high together.
- R11: desc_rd and desc_wr are never high in the same cycle, and every writeback is followed by a fetch in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | IDX_W | Ring start index |
| tx_poll | input | 1 | Look-for-work strobe |
| mac_status | input | 7 | Completion status from the MAC, written into final descriptors |
| desc_rd | output | 1 | Descriptor read request |
| desc_wr | output | 1 | Descriptor writeback |
| desc_addr | output | IDX_W | Descriptor index for read or write |
| desc_wdata | output | 64 | Writeback word |
| desc_rdata | input | 64 | Descriptor word, one cycle after desc_rd |
| buf_rd | output | 1 | Buffer byte read request |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_rdata | input | 8 | Buffer byte, one cycle after buf_rd |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_crc | output | 1 | Append CRC after this frame |
| evt_frame | output | 1 | Frame-complete event pulse |
| evt_buf | output | 1 | Buffer-complete event pulse |

## Verification
The fetch is due in the cycle after the poll. The first byte read comes two cycles after the fetch, and each byte reaches the stream one cycle after its read. The writeback follows two cycles after the final read or pad byte, with any event pulse in that same cycle. A directed case samples desc_rd, buf_rd and the first stream byte at exactly those cycles, on the falling edge. All other scenarios wait until the ports stay quiet for ten cycles. They then compare the captured byte stream with its markers, the descriptor memory image, and the running totals of fetches and event pulses against a bench model. The model walks the same ring from the requirements.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int CTL_READY = 15;
  localparam int CTL_WRAP  = 13;
  localparam int CTL_IRQ   = 12;
  localparam int CTL_LAST  = 11;
  localparam int CTL_CRC   = 10;
  localparam int STAT_W    = 10;
  localparam int MSTAT_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_SEND,
    ST_WB
  } txr_state_e;

  typedef struct packed {
    logic [31:0] ptr;
    logic [15:0] len;
    logic [15:0] ctl;
  } txr_desc_t;

  // control half-word written back: ownership returned, flags kept, status replaced
  function automatic logic [15:0] wb_ctl(input logic [15:0] ctl,
                                         input logic [MSTAT_W-1:0] mstat);
    logic [STAT_W-1:0] st;
    st = ctl[CTL_LAST] ? STAT_W'(mstat) : '0;
    return {1'b0, ctl[14:10], st};
  endfunction

  // a frame unit closes the frame once the running count reaches the minimum
  function automatic logic closes_frame(input logic last, input logic final_unit,
                                        input logic [15:0] cnt_after,
                                        input logic [15:0] min_len);
    return last && final_unit && (cnt_after >= min_len);
  endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ring_base,
  input  logic             advance,
  input  logic             wrap,
  output logic [IDX_W-1:0] cur_idx
);
  logic             started_q;
  logic [IDX_W-1:0] idx_q;

  assign cur_idx = started_q ? idx_q : ring_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      idx_q     <= '0;
    end else if (advance) begin
      started_q <= 1'b1;
      idx_q     <= wrap ? ring_base : cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/txr_byte_sched.sv
module txr_byte_sched #(
  parameter int BUF_AW    = 16,
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [BUF_AW-1:0] ld_ptr,
  input  logic              ld_last,
  input  logic              ld_crc,
  input  logic              run,
  input  logic              frame_clr,
  output logic              issue,
  output logic              pad,
  output logic              sof,
  output logic              eof,
  output logic              crc_req,
  output logic              done,
  output logic [BUF_AW-1:0] rd_addr
);
  import txr_pkg::*;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

  logic [LEN_W-1:0]  rem_q;
  logic [BUF_AW-1:0] addr_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic              last_q, crc_q;

  logic             have_data, need_pad, final_unit;
  logic [CNT_W-1:0] fcnt_nx;

  assign have_data  = (rem_q != '0);
  assign need_pad   = last_q && (fcnt_q < MIN_C);
  assign issue      = run && (have_data || need_pad);
  assign pad        = run && !have_data && need_pad;
  assign done       = run && !have_data && !need_pad;
  assign fcnt_nx    = (fcnt_q == '1) ? fcnt_q : fcnt_q + 1'b1;
  assign final_unit = have_data ? (rem_q == LEN_W'(1)) : 1'b1;
  assign sof        = (fcnt_q == '0);
  assign eof        = closes_frame(last_q, final_unit, fcnt_nx, MIN_C);
  assign crc_req    = eof && crc_q;
  assign rd_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      fcnt_q <= '0;
      last_q <= 1'b0;
      crc_q  <= 1'b0;
    end else if (load) begin
      rem_q  <= ld_len;
      addr_q <= ld_ptr;
      last_q <= ld_last;
      crc_q  <= ld_crc;
    end else if (frame_clr) begin
      fcnt_q <= '0;
    end else if (issue) begin
      fcnt_q <= fcnt_nx;
      if (have_data) begin
        rem_q  <= rem_q - 1'b1;
        addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txr_out_stage.sv
module txr_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic       pad,
  input  logic       sof,
  input  logic       eof,
  input  logic       crc_req,
  input  logic [7:0] buf_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_sof,
  output logic       tx_eof,
  output logic       tx_crc
);
  logic pad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      pad_q    <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
      tx_crc   <= 1'b0;
    end else begin
      tx_valid <= issue;
      pad_q    <= issue && pad;
      tx_sof   <= issue && sof;
      tx_eof   <= issue && eof;
      tx_crc   <= issue && crc_req;
    end
  end

  assign tx_data = (tx_valid && !pad_q) ? buf_rdata : 8'h00;
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int IDX_W     = 4,
  parameter int BUF_AW    = 16,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ring_base,
  input  logic              tx_poll,
  input  logic [6:0]        mac_status,
  output logic              desc_rd,
  output logic              desc_wr,
  output logic [IDX_W-1:0]  desc_addr,
  output logic [63:0]       desc_wdata,
  input  logic [63:0]       desc_rdata,
  output logic              buf_rd,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_crc,
  output logic              evt_frame,
  output logic              evt_buf
);
  import txr_pkg::*;

  txr_state_e state_q, state_nx;
  logic       pend_q;
  txr_desc_t  desc_q, rd_desc;

  // named internal events
  logic fetch_go, desc_ready, load_go, wb_fire, frame_end;
  logic issue, pad, sof, eof, crc_req, done;
  logic [IDX_W-1:0] cur_idx;

  assign rd_desc    = txr_desc_t'(desc_rdata);
  assign fetch_go   = (state_q == ST_IDLE) && (tx_poll || pend_q);
  assign desc_ready = rd_desc.ctl[CTL_READY];
  assign load_go    = (state_q == ST_DECODE) && desc_ready;
  assign wb_fire    = (state_q == ST_WB);
  assign frame_end  = wb_fire && desc_q.ctl[CTL_LAST];

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE:   if (fetch_go) state_nx = ST_FETCH;
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: state_nx = desc_ready ? ST_SEND : ST_IDLE;
      ST_SEND:   if (done) state_nx = ST_WB;
      ST_WB:     state_nx = ST_FETCH;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      desc_q  <= '0;
    end else begin
      state_q <= state_nx;
      pend_q  <= (state_q == ST_IDLE) ? 1'b0 : (pend_q || tx_poll);
      if (load_go) desc_q <= rd_desc;
    end
  end

  txr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .advance   (wb_fire),
    .wrap      (desc_q.ctl[CTL_WRAP]),
    .cur_idx   (cur_idx)
  );

  txr_byte_sched #(
    .BUF_AW    (BUF_AW),
    .LEN_W     (16),
    .MIN_FRAME (MIN_FRAME)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_go),
    .ld_len    (rd_desc.len),
    .ld_ptr    (rd_desc.ptr[BUF_AW-1:0]),
    .ld_last   (rd_desc.ctl[CTL_LAST]),
    .ld_crc    (rd_desc.ctl[CTL_CRC]),
    .run       (state_q == ST_SEND),
    .frame_clr (frame_end),
    .issue     (issue),
    .pad       (pad),
    .sof       (sof),
    .eof       (eof),
    .crc_req   (crc_req),
    .done      (done),
    .rd_addr   (buf_addr)
  );

  txr_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .pad       (pad),
    .sof       (sof),
    .eof       (eof),
    .crc_req   (crc_req),
    .buf_rdata (buf_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_sof    (tx_sof),
    .tx_eof    (tx_eof),
    .tx_crc    (tx_crc)
  );

  assign buf_rd     = issue && !pad;
  assign desc_rd    = (state_q == ST_FETCH);
  assign desc_wr    = wb_fire;
  assign desc_addr  = cur_idx;
  assign desc_wdata = {desc_q.ptr, desc_q.len, wb_ctl(desc_q.ctl, mac_status)};
  assign evt_frame  = frame_end && desc_q.ctl[CTL_IRQ];
  assign evt_buf    = wb_fire && !desc_q.ctl[CTL_LAST] && desc_q.ctl[CTL_IRQ];
endmodule

// File: rtl/txr_checks.sv
module txr_checks #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] ring_base,
  input logic             desc_rd,
  input logic             desc_wr,
  input logic [IDX_W-1:0] desc_addr,
  input logic [63:0]      desc_wdata,
  input logic             buf_rd,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_sof,
  input logic             tx_eof,
  input logic             tx_crc,
  input logic             evt_frame,
  input logic             evt_buf
);
  assert_desc_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_rd && desc_wr));
  assert_wb_then_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |=> desc_rd);
  assert_owner_returned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |-> !desc_wdata[15]);
  assert_wrap_to_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && desc_wdata[13]) |=> (desc_addr == ring_base));
  assert_evt_in_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_frame || evt_buf) |-> desc_wr);
  assert_evt_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_frame && evt_buf));
  assert_evt_frame_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame |-> (desc_wdata[11] && desc_wdata[12]));
  assert_markers_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> tx_valid);
  assert_crc_on_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_crc |-> tx_eof);
  assert_read_to_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |=> tx_valid);
  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !$past(buf_rd)) |-> (tx_data == 8'h00));
endmodule

bind txr_engine txr_checks #(.IDX_W(IDX_W)) u_txr_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .ring_base  (ring_base),
  .desc_rd    (desc_rd),
  .desc_wr    (desc_wr),
  .desc_addr  (desc_addr),
  .desc_wdata (desc_wdata),
  .buf_rd     (buf_rd),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_sof     (tx_sof),
  .tx_eof     (tx_eof),
  .tx_crc     (tx_crc),
  .evt_frame  (evt_frame),
  .evt_buf    (evt_buf)
);

// File: tb/test_txr_engine.sv
module test_txr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int RING  = 16;
  localparam int BUF_AW = 16;
  localparam int MINF  = 60;
  localparam int QD    = 4096;
  localparam logic [15:0] F_RDY = 16'h8000, F_WRAP = 16'h2000, F_IRQ = 16'h1000,
                          F_LAST = 16'h0800, F_CRC = 16'h0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDX_W-1:0] base = '0;
  logic tx_poll = 1'b0;
  logic [6:0] mstat = '0;
  logic desc_rd, desc_wr, buf_rd, tx_valid, tx_sof, tx_eof, tx_crc, evt_frame, evt_buf;
  logic [IDX_W-1:0] desc_addr;
  logic [63:0] desc_wdata;
  logic [63:0] desc_rdata;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_rdata, tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  txr_engine #(.IDX_W(IDX_W), .BUF_AW(BUF_AW), .MIN_FRAME(MINF)) i_txr_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(base), .tx_poll(tx_poll), .mac_status(mstat),
    .desc_rd(desc_rd), .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
    .desc_rdata(desc_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_crc(tx_crc), .evt_frame(evt_frame), .evt_buf(evt_buf));

  function automatic logic [7:0] bdat(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'd29;
    return m[7:0] ^ a[11:4];
  endfunction

  // memories seen by the engine, plus software write path
  logic [63:0] dmem [RING];
  logic sw_we = 1'b0;
  logic [IDX_W-1:0] sw_idx = '0;
  logic [63:0] sw_data = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RING; i++) dmem[i] <= '0;
      desc_rdata <= '0;
      buf_rdata <= '0;
    end else begin
      if (desc_rd) desc_rdata <= dmem[desc_addr];
      if (desc_wr) dmem[desc_addr] <= desc_wdata;
      if (sw_we) dmem[sw_idx] <= sw_data;
      if (buf_rd) buf_rdata <= bdat(buf_addr);
    end
  end

  // port monitor
  logic [10:0] act_s [QD];
  int act_n = 0, rd_cnt = 0, ef_cnt = 0, eb_cnt = 0;
  logic [IDX_W-1:0] last_rd_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        act_s[act_n % QD] <= {tx_crc, tx_eof, tx_sof, tx_data};
        act_n <= act_n + 1;
      end
      if (desc_rd) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= desc_addr;
      end
      if (evt_frame) ef_cnt <= ef_cnt + 1;
      if (evt_buf) eb_cnt <= eb_cnt + 1;
    end
  end

  // bench model state
  logic [63:0] exp_mem [RING];
  logic [10:0] exp_s [QD];
  int exp_n = 0, cmp_n = 0, e_rd = 0, e_ef = 0, e_eb = 0, m_fcnt = 0, m_idx = 0;
  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [10:0] v);
    exp_s[exp_n % QD] = v;
    exp_n++;
  endtask

  task automatic arm(input int idx, input logic [15:0] ctl, input int len,
                     input logic [15:0] ptr);
    logic [63:0] w;
    w = {16'h0, ptr, 16'(len), ctl};
    exp_mem[idx] = w;
    @(negedge clk);
    sw_we = 1'b1; sw_idx = IDX_W'(idx); sw_data = w;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic poll();
    @(negedge clk);
    tx_poll = 1'b1;
    @(negedge clk);
    tx_poll = 1'b0;
  endtask

  // walk the ring from the requirements
  task automatic model_run(input int extra);
    int idx, len;
    logic [63:0] d;
    logic [15:0] c, ptr, wc;
    bit ef;
    idx = m_idx;
    while (exp_mem[idx][15]) begin
      d = exp_mem[idx]; c = d[15:0]; len = int'(d[31:16]); ptr = d[47:32];
      e_rd++;
      for (int k = 0; k < len; k++) begin
        ef = c[11] && (k == len - 1) && (m_fcnt + 1 >= MINF);
        push({c[10] && ef, ef, m_fcnt == 0, bdat(ptr + 16'(k))});
        m_fcnt++;
      end
      if (c[11]) begin
        while (m_fcnt < MINF) begin
          ef = (m_fcnt + 1 == MINF);
          push({c[10] && ef, ef, m_fcnt == 0, 8'h00});
          m_fcnt++;
        end
      end
      wc = {1'b0, c[14:10], c[11] ? {3'b000, mstat} : 10'h000};
      if (c[12]) begin
        if (c[11]) e_ef++; else e_eb++;
      end
      if (c[11]) m_fcnt = 0;
      exp_mem[idx] = {d[63:16], wc};
      idx = c[13] ? int'(base) : (idx + 1) % RING;
    end
    m_idx = idx;
    e_rd = e_rd + 1 + extra;
  endtask

  task automatic wait_idle();
    int q;
    q = 0;
    while (q < 10) begin
      @(negedge clk);
      if (desc_rd || desc_wr || buf_rd || tx_valid) q = 0; else q++;
    end
  endtask

  task automatic verify(input string tag);
    int bad;
    wait_idle();
    check(act_n == exp_n, {tag, " R4 R5 R6 stream byte count"}, 64'(act_n), 64'(exp_n));
    bad = -1;
    for (int i = cmp_n; i < exp_n && i < act_n; i++)
      if (bad < 0 && act_s[i % QD] !== exp_s[i % QD]) bad = i;
    if (bad >= 0)
      check(1'b0, {tag, " R4 R5 R6 R7 stream byte/markers"}, 64'(act_s[bad % QD]),
            64'(exp_s[bad % QD]));
    else
      check(1'b1, {tag, " R4 R5 R6 R7 stream"}, 0, 0);
    bad = -1;
    for (int i = 0; i < RING; i++) if (bad < 0 && dmem[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) check(1'b0, {tag, " R8 descriptor writeback"}, dmem[bad], exp_mem[bad]);
    else check(1'b1, {tag, " R8 writeback"}, 0, 0);
    check(ef_cnt == e_ef, {tag, " R10 evt_frame count"}, 64'(ef_cnt), 64'(e_ef));
    check(eb_cnt == e_eb, {tag, " R10 evt_buf count"}, 64'(eb_cnt), 64'(e_eb));
    check(rd_cnt == e_rd, {tag, " R2 R3 R11 fetch count"}, 64'(rd_cnt), 64'(e_rd));
    cmp_n = exp_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
    $finish;
  end

  initial begin
    int k, idx, len;
    logic [15:0] ctl;
    void'($urandom(32'd4242));
    for (int i = 0; i < RING; i++) exp_mem[i] = '0;

    // R1 reset state
    repeat (4) @(negedge clk);
    check(!desc_rd && !desc_wr, "R1 descriptor port idle in reset", {desc_rd, desc_wr}, 0);
    check(!buf_rd && !tx_valid, "R1 byte path idle in reset", {buf_rd, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!desc_rd && !desc_wr && !buf_rd, "R1 no fetch before poll",
          {desc_rd, desc_wr, buf_rd}, 0);
    check(!tx_valid && !evt_frame && !evt_buf, "R1 outputs low before poll",
          {tx_valid, evt_frame, evt_buf}, 0);

    // single frame with cycle-exact sampling
    arm(0, F_RDY | F_LAST | F_CRC | F_IRQ, 100, 16'h0100);
    mstat = 7'h15;
    model_run(0);
    @(negedge clk); tx_poll = 1'b1;
    @(negedge clk); tx_poll = 1'b0;
    check(desc_rd && desc_addr == 0, "R2 fetch one cycle after poll at ring_base",
          {desc_rd, 4'(desc_addr)}, 64'h10);
    @(negedge clk);
    check(!desc_rd && !buf_rd, "R4 decode cycle quiet", {desc_rd, buf_rd}, 0);
    @(negedge clk);
    check(buf_rd && buf_addr == 16'h0100, "R4 first read two cycles after fetch",
          {buf_rd, buf_addr}, 64'h10100);
    @(negedge clk);
    check(tx_valid && tx_sof && tx_data == bdat(16'h0100), "R4 first byte with sof",
          {tx_valid, tx_sof, tx_data}, {2'b11, bdat(16'h0100)});
    verify("single");

    // short frame padded
    mstat = 7'h7F;
    arm(1, F_RDY | F_LAST | F_IRQ, 10, 16'h0300);
    model_run(0); poll(); verify("R6 short");

    // multi-buffer frames
    mstat = 7'h42;
    arm(2, F_RDY | F_IRQ, 20, 16'h0400);
    arm(3, F_RDY | F_LAST | F_CRC, 30, 16'h0500);
    arm(4, F_RDY, 40, 16'h0600);
    arm(5, F_RDY | F_LAST | F_IRQ | F_CRC, 40, 16'h0700);
    model_run(0); poll(); verify("R5 multi");

    // not ready: nothing happens
    model_run(0); poll(); verify("R3 not-ready");

    // poll while busy is remembered
    arm(6, F_RDY | F_LAST, 200, 16'h0800);
    model_run(1); poll();
    repeat (40) @(negedge clk);
    poll(); verify("R2 pending poll");

    // wrap to a moved base
    @(negedge clk); base = 4'd4;
    arm(7, F_RDY | F_LAST | F_WRAP, 30, 16'h0900);
    arm(4, F_RDY | F_LAST | F_IRQ, 64, 16'h0A00);
    model_run(0); poll(); verify("R9 wrap");
    check(last_rd_addr == 4'd5, "R9 fetch after wrapped descriptor", 64'(last_rd_addr), 5);

    // random rounds
    @(negedge clk); base = '0;
    for (int r = 0; r < 12; r++) begin
      mstat = 7'($urandom);
      k = 1 + int'($urandom % 3);
      idx = m_idx;
      for (int j = 0; j < k; j++) begin
        len = 1 + int'($urandom % 64);
        ctl = F_RDY;
        if ($urandom % 2) ctl |= F_IRQ;
        if ($urandom % 2) ctl |= F_CRC;
        if (j == k - 1 || ($urandom % 4) == 0) ctl |= F_LAST;
        if (idx == RING - 1) ctl |= F_WRAP;
        arm(idx, ctl, len, 16'($urandom % 32'h7000));
        idx = (ctl & F_WRAP) != 0 ? int'(base) : (idx + 1) % RING;
      end
      model_run(0); poll(); verify("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule